// File: doc/BRIEF.md
# Coherent BPSK Bit Recovery with a Shared-Multiplier Low-Pass Filter

This block turns a stream of 16-bit signed BPSK samples into hard bit decisions. It mixes every accepted sample with a locally generated carrier at one quarter of the sample rate, so the carrier takes the values +A, 0, -A, 0 in turn. The mixer product goes into a 128-tap symmetric low-pass filter. The filter uses one multiplier and one accumulator, and it works through all 128 taps one per clock for every sample. Each filter result is rounded, saturated to 16 bits and then sliced against zero into a single bit.

Samples enter through a valid/ready pair. While a filter pass is running, ready stays low, so a sample offered during the pass waits upstream until the pass completes. Each accepted sample produces one filtered value with its own strobe. The bit decision and its strobe follow one cycle later, after the comparator register. Carrier phase and symbol timing are fixed by the order of samples since reset. No carrier or timing recovery is attempted.

Top module: `bpsk_coh_demod`

## Requirements
- R1: While reset is held, and in the first cycle after it, in_ready is 1, filt_valid and bit_valid are 0, and filt_out and bit_out are 0.
- R2: The k-th sample accepted since reset (k counted from 0) is multiplied by a carrier value chosen by k mod 4: 32767, 0, -32767, 0 for residues 0, 1, 2, 3. The product is arithmetically shifted right by 15 (rounding toward minus infinity) to give the mixed value x[k].
- R3: For the n-th accepted sample, the accumulated sum is the sum over j = 0..127 of h[j]*x[n-j], with h[j] = 4*(min(j, 127-j)+1). Mixed values from before reset count as zero.
- R4: filt_out is the sum plus 4096, arithmetically shifted right by 13, then saturated to the range -32768..32767.
- R5: filt_valid is a single-cycle pulse. It rises after the 132nd rising clock edge that follows the edge which accepted the sample, and it does not rise earlier.
- R6: in_ready falls after an accepting edge and rises again together with filt_valid. A sample held on in_data with in_valid high while in_ready is low is accepted only at the first edge after in_ready rises, and it is processed exactly once.
- R7: One cycle after each filt_valid pulse, bit_valid pulses for one cycle and bit_out shows 1 if that filt_out was greater than or equal to zero, and 0 otherwise.
- R8: filt_out and bit_out keep their last values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample is offered on in_data |
| in_ready | output | 1 | The block can take a sample this cycle |
| in_data | input | 16 | Received sample, two's complement |
| filt_valid | output | 1 | Single-cycle strobe for filt_out |
| filt_out | output | 16 | Rounded, saturated low-pass result, two's complement |
| bit_valid | output | 1 | Single-cycle strobe for bit_out |
| bit_out | output | 1 | Hard decision: 1 when the filter result is not negative |

## Verification
Counting from the edge that accepts a sample, the filtered value is due after the 132nd following edge: three mixer stages, one buffer write, 128 accumulate steps and the output register. The bit is due one edge after that. For every sample, the bench counts falling edges from the accepting edge. It confirms that neither strobe appears and that ready stays low through falling edge 131. It compares filt_out and in_ready at falling edge 132, and bit_out and bit_valid at falling edge 133. Held samples are raised partway through a pass, so their acceptance lands on edge 133 and the next count starts from there.

// File: rtl/bpsk_demod_pkg.sv
// Package: shared constants and elaboration-time helpers for the BPSK demodulator.
// Assumes: callers pass a positive tap count and step.
package bpsk_demod_pkg;

    // Triangular symmetric low-pass tap value for index i of a taps-long filter.
    function automatic int tri_coef(input int i, input int taps, input int step);
        int m;
        m = (i < (taps - 1 - i)) ? i : (taps - 1 - i);
        return step * (m + 1);
    endfunction

    // Quarter-rate carrier value for a two-bit phase index.
    function automatic int quarter_carrier(input int phase, input int amp);
        case (phase)
            0:       return amp;
            2:       return -amp;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/carrier_mixer.sv
// Module: carrier_mixer
// Multiplies each accepted sample by a quarter-rate local carrier (+A, 0, -A, 0).
// Three register stages: operand capture, product, scaled result.
// Assumes: take pulses only when the top accepts a sample; CARR_AMP < 2**(DATA_W-1).
module carrier_mixer
    import bpsk_demod_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CARR_AMP = 32767
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     take,
    input  logic signed [DATA_W-1:0] samp,
    output logic                     mix_valid,
    output logic signed [DATA_W-1:0] mix_data
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int SCALE  = DATA_W - 1;

    logic [1:0]               phase_q;
    logic signed [DATA_W-1:0] op_a_q;
    logic signed [DATA_W-1:0] op_b_q;
    logic signed [PROD_W-1:0] prod_q;
    logic signed [PROD_W-1:0] scaled;
    logic                     v1_q;
    logic                     v2_q;
    logic signed [DATA_W-1:0] carr_now;

    // Carrier value for the current phase.
    assign carr_now = DATA_W'(quarter_carrier(int'(phase_q), CARR_AMP));

    // Stage 1: capture operands and advance the carrier phase per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            op_a_q  <= '0;
            op_b_q  <= '0;
            v1_q    <= 1'b0;
        end else begin
            v1_q <= take;
            if (take) begin
                op_a_q  <= samp;
                op_b_q  <= carr_now;
                phase_q <= phase_q + 2'd1;
            end
        end
    end

    // Stage 2: full-precision signed product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            v2_q   <= 1'b0;
        end else begin
            v2_q   <= v1_q;
            prod_q <= op_a_q * op_b_q;
        end
    end

    // Arithmetic rescale back to sample width.
    assign scaled = prod_q >>> SCALE;

    // Stage 3: register the rescaled product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mix_data  <= '0;
            mix_valid <= 1'b0;
        end else begin
            mix_valid <= v2_q;
            mix_data  <= scaled[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/mac_lowpass.sv
// Module: mac_lowpass
// Time-multiplexed FIR: a circular history buffer, a tap counter and one
// multiply-accumulate run TAPS cycles per input, then round and saturate.
// Assumes: TAPS is a power of two; no new input arrives while a pass runs.
module mac_lowpass
    import bpsk_demod_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int COEF_W    = 16,
    parameter int TAPS      = 128,
    parameter int ACC_W     = 40,
    parameter int COEF_STEP = 4,
    parameter int OUT_SHIFT = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     pass_done,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);
    localparam int IDX_W  = $clog2(TAPS);
    localparam int TERM_W = DATA_W + COEF_W;
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (OUT_SHIFT - 1);
    localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SMIN = -(SMAX + ACC_W'(1));

    logic signed [COEF_W-1:0] coef_tab [TAPS];
    logic signed [DATA_W-1:0] hist_q   [TAPS];
    logic [IDX_W-1:0]         head_q;
    logic [IDX_W-1:0]         tap_q;
    logic [IDX_W-1:0]         rd_idx;
    logic                     run_q;
    logic                     fin_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [TERM_W-1:0] term;
    logic signed [ACC_W-1:0]  term_ext;
    logic signed [ACC_W-1:0]  rounded;
    logic signed [DATA_W-1:0] clipped;

    // Constant coefficient table, one entry per tap.
    for (genvar g = 0; g < TAPS; g++) begin : g_coef
        assign coef_tab[g] = COEF_W'(tri_coef(g, TAPS, COEF_STEP));
    end

    // Newest sample sits at head; older ones follow backwards.
    assign rd_idx   = head_q - tap_q;
    assign term     = hist_q[rd_idx] * coef_tab[tap_q];
    assign term_ext = {{(ACC_W - TERM_W){term[TERM_W-1]}}, term};

    // History write: advance head and store the new mixed sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            for (int i = 0; i < TAPS; i++) hist_q[i] <= '0;
        end else if (in_valid) begin
            head_q                 <= head_q + IDX_W'(1);
            hist_q[head_q + IDX_W'(1)] <= in_data;
        end
    end

    // Pass control and accumulation: clear on a new sample, add one tap per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            fin_q <= 1'b0;
            tap_q <= '0;
            acc_q <= '0;
        end else if (in_valid) begin
            run_q <= 1'b1;
            fin_q <= 1'b0;
            tap_q <= '0;
            acc_q <= '0;
        end else if (run_q) begin
            acc_q <= acc_q + term_ext;
            tap_q <= tap_q + IDX_W'(1);
            if (tap_q == IDX_W'(TAPS - 1)) begin
                run_q <= 1'b0;
                fin_q <= 1'b1;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign pass_done = fin_q;

    // Round half up and clip to the output width.
    always_comb begin
        rounded = (acc_q + RND) >>> OUT_SHIFT;
        if (rounded > SMAX)      clipped = SMAX[DATA_W-1:0];
        else if (rounded < SMIN) clipped = SMIN[DATA_W-1:0];
        else                     clipped = rounded[DATA_W-1:0];
    end

    // Output register: update and strobe once per finished pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= fin_q;
            if (fin_q) out_data <= clipped;
        end
    end
endmodule

// File: rtl/sign_slicer.sv
// Module: sign_slicer
// Registered greater-or-equal-to-zero comparison followed by a 1/0 select.
// Assumes: in_valid is a single-cycle strobe.
module sign_slicer #(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     dec_valid,
    output logic                     dec_bit
);
    logic cmp_q;

    // Comparator register: captured only on a strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q     <= 1'b0;
            dec_valid <= 1'b0;
        end else begin
            dec_valid <= in_valid;
            if (in_valid) cmp_q <= (in_data >= 0);
        end
    end

    // Constant select driven by the comparator.
    assign dec_bit = cmp_q ? 1'b1 : 1'b0;
endmodule

// File: rtl/bpsk_coh_demod.sv
// Module: bpsk_coh_demod (top)
// Mixer -> shared-MAC low-pass -> sign slicer, with valid/ready input flow control.
// Assumes: upstream holds in_data stable while in_valid is high and in_ready low.
module bpsk_coh_demod #(
    parameter int DATA_W    = 16,
    parameter int COEF_W    = 16,
    parameter int TAPS      = 128,
    parameter int ACC_W     = 40,
    parameter int COEF_STEP = 4,
    parameter int OUT_SHIFT = 13,
    parameter int CARR_AMP  = 32767
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     filt_valid,
    output logic signed [DATA_W-1:0] filt_out,
    output logic                     bit_valid,
    output logic                     bit_out
);
    logic                     busy_q;
    logic                     take;
    logic                     mix_valid;
    logic signed [DATA_W-1:0] mix_data;
    logic                     pass_done;

    assign in_ready = !busy_q;
    assign take     = in_valid && !busy_q;

    // Busy flag: set on acceptance, cleared when the MAC pass finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (take)      busy_q <= 1'b1;
        else if (pass_done) busy_q <= 1'b0;
    end

    carrier_mixer #(
        .DATA_W  (DATA_W),
        .CARR_AMP(CARR_AMP)
    ) mixer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .samp     (in_data),
        .mix_valid(mix_valid),
        .mix_data (mix_data)
    );

    mac_lowpass #(
        .DATA_W   (DATA_W),
        .COEF_W   (COEF_W),
        .TAPS     (TAPS),
        .ACC_W    (ACC_W),
        .COEF_STEP(COEF_STEP),
        .OUT_SHIFT(OUT_SHIFT)
    ) fir_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (mix_valid),
        .in_data  (mix_data),
        .pass_done(pass_done),
        .out_valid(filt_valid),
        .out_data (filt_out)
    );

    sign_slicer #(
        .DATA_W(DATA_W)
    ) slicer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (filt_valid),
        .in_data  (filt_out),
        .dec_valid(bit_valid),
        .dec_bit  (bit_out)
    );
endmodule

// File: rtl/bpsk_coh_demod_chk.sv
// Module: bpsk_coh_demod_chk
// Port-level protocol and timing checks, bound to every bpsk_coh_demod instance.
// Assumes: the accept-to-result distance is TAPS+4 edges.
module bpsk_coh_demod_chk #(
    parameter int DATA_W = 16,
    parameter int TAPS   = 128
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     filt_valid,
    input logic signed [DATA_W-1:0] filt_out,
    input logic                     bit_valid,
    input logic                     bit_out
);
    localparam int LAT_CNT = TAPS + 5;
    localparam int CNT_W   = $clog2(TAPS + 8) + 1;

    logic [CNT_W-1:0] cnt_q;

    // Cycle counter since the last accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (in_valid && in_ready) cnt_q <= CNT_W'(1);
        else if (filt_valid)           cnt_q <= '0;
        else if (cnt_q != '0)          cnt_q <= cnt_q + CNT_W'(1);
    end

    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (filt_valid == (cnt_q == CNT_W'(LAT_CNT))));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        filt_valid |=> !filt_valid);

    a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r6_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
        filt_valid |-> in_ready);

    a_r7_bit_follows: assert property (@(posedge clk) disable iff (!rst_n)
        filt_valid |=> bit_valid);

    a_r7_bit_source: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(filt_valid));

    a_r7_bit_sign: assert property (@(posedge clk) disable iff (!rst_n)
        filt_valid |=> (bit_out == !$past(filt_out[DATA_W-1])));

    a_r8_filt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_valid |-> $stable(filt_out));

    a_r8_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> $stable(bit_out));
endmodule

bind bpsk_coh_demod bpsk_coh_demod_chk #(
    .DATA_W(DATA_W),
    .TAPS  (TAPS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .filt_valid(filt_valid),
    .filt_out  (filt_out),
    .bit_valid (bit_valid),
    .bit_out   (bit_out)
);

// File: tb/bpsk_coh_demod_tb_top.sv
`timescale 1ns/1ps
module bpsk_coh_demod_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic signed [15:0] in_data = '0;
    logic               filt_valid;
    logic signed [15:0] filt_out;
    logic               bit_valid;
    logic               bit_out;

    int     n_cmp = 0;
    int     n_bad = 0;
    int     cycles = 0;
    bit     done = 1'b0;
    longint mixh [0:1023];
    int     nacc = 0;
    longint prev_y = 0;
    bit     prev_b = 1'b0;

    always #10 clk = ~clk;

    bpsk_coh_demod dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .filt_valid(filt_valid),
        .filt_out  (filt_out),
        .bit_valid (bit_valid),
        .bit_out   (bit_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (sample %0d)", req, act, exp, nacc);
        end
    endtask

    // Expected filter output for the newest accepted sample (R3, R4).
    function automatic longint model_y();
        longint acc = 0;
        longint r;
        for (int j = 0; j < 128; j++) begin
            int m = (j < 127 - j) ? j : 127 - j;
            if (nacc - 1 - j >= 0) acc += longint'(4 * (m + 1)) * mixh[nacc - 1 - j];
        end
        r = (acc + 4096) >>> 13;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    // Offer one sample, follow it through the pipeline and check every due result.
    task automatic do_sample(input logic signed [15:0] s, input bit already,
                             input bit preload, input logic signed [15:0] nxt,
                             input string tag);
        longint cv, y;
        bit     b;
        int     early_bad = 0;
        if (!already) begin
            in_valid = 1'b1;
            in_data  = s;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        // R2: carrier by acceptance index mod 4.
        case (nacc % 4)
            0: cv = 32767;
            2: cv = -32767;
            default: cv = 0;
        endcase
        mixh[nacc] = (longint'(s) * cv) >>> 15;
        nacc++;
        y = model_y();
        b = (y >= 0);
        for (int c = 1; c <= 131; c++) begin
            @(negedge clk);
            if (filt_valid || bit_valid || in_ready) early_bad++;
            if (c == 60) begin
                chk(filt_out == prev_y, "R8 filt hold", filt_out, prev_y);
                chk(bit_out == prev_b, "R8 bit hold", bit_out, prev_b);
            end
            if (preload && c == 5) begin
                in_valid = 1'b1;
                in_data  = nxt;
            end
        end
        chk(early_bad == 0, "R5 R6 early strobe or ready", early_bad, 0);
        @(negedge clk);
        chk(filt_valid == 1'b1, "R5 filt strobe", filt_valid, 1);
        chk(filt_out == y, tag, filt_out, y);
        chk(in_ready == 1'b1, "R6 ready back", in_ready, 1);
        chk(bit_valid == 1'b0, "R7 bit not yet", bit_valid, 0);
        @(negedge clk);
        chk(bit_valid == 1'b1, "R7 bit strobe", bit_valid, 1);
        chk(bit_out == b, "R7 bit value", bit_out, b);
        chk(filt_valid == 1'b0, "R5 single pulse", filt_valid, 0);
        prev_y = y;
        prev_b = b;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !done) begin
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 190000);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic signed [15:0] s;
        int d;
        int amp;
        for (int i = 0; i < 1024; i++) mixh[i] = 0;
        repeat (4) @(negedge clk);
        // R1: state during reset.
        chk(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
        chk(filt_valid == 1'b0, "R1 filt_valid in reset", filt_valid, 0);
        chk(bit_valid == 1'b0, "R1 bit_valid in reset", bit_valid, 0);
        chk(filt_out == 0, "R1 filt_out in reset", filt_out, 0);
        chk(bit_out == 1'b0, "R1 bit_out in reset", bit_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && !filt_valid && !bit_valid, "R1 after release",
            {in_ready, filt_valid, bit_valid}, 3'b100);

        // R2 R3: BPSK-like stream, symbols of 16 samples, random amplitude, junk on odd phases.
        d = 1;
        amp = 12000;
        for (int n = 0; n < 320; n++) begin
            if (n % 16 == 0) begin
                d   = ($urandom % 2) ? 1 : -1;
                amp = 2000 + int'($urandom % 28000);
            end
            case (nacc % 4)
                0: s = 16'(d * amp);
                2: s = 16'(-d * amp);
                default: s = 16'($urandom);
            endcase
            do_sample(s, 1'b0, 1'b0, '0, "R2 R3 filtered value");
        end

        // R4: positive saturation with full-scale in-phase input.
        for (int n = 0; n < 150; n++) begin
            case (nacc % 4)
                0: s = 16'sd32767;
                2: s = -16'sd32768;
                default: s = 16'($urandom);
            endcase
            do_sample(s, 1'b0, 1'b0, '0, "R4 positive clip");
        end

        // R4: negative saturation.
        for (int n = 0; n < 150; n++) begin
            case (nacc % 4)
                0: s = -16'sd32768;
                2: s = 16'sd32767;
                default: s = 16'($urandom);
            endcase
            do_sample(s, 1'b0, 1'b0, '0, "R4 negative clip");
        end

        // R6: next sample raised during the pass and held until ready returns.
        begin
            logic signed [15:0] cur;
            logic signed [15:0] nx;
            cur = 16'($urandom);
            for (int n = 0; n < 40; n++) begin
                nx = 16'($urandom);
                do_sample(cur, n != 0, n != 39, nx, "R6 held sample value");
                cur = nx;
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule